// File: doc/BRIEF.md
# DRAM Refresh Interval Rescaler

This block keeps the auto-refresh count of two memory controller channels in step with their memory clock. When software or a clock sequencer is about to move a channel to a new frequency, it asks this block for the refresh count that keeps the refresh interval constant at the new rate. The block then writes that count to the channel's refresh register output, which the memory controller consumes directly.

Each channel is first calibrated. A calibration event supplies the refresh count in use and the channel's clock in Hz. The block keeps the count scaled by 1000 and the frequency, and it loads the count into the register output at once. A later request names a channel and a target frequency in kHz. The block divides the stored frequency by the target to get a ratio, then divides the scaled count by that ratio. Both divisions truncate and run one after the other on a single shared serial divider, one quotient bit per cycle.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle. A source holding `req_valid` high while `req_ready` is low keeps its payload, and nothing is taken until a cycle where both are high. Completion is reported by a single-cycle `done`, with `err` beside it when the request was refused.

Top module: `refresh_rescaler`

## Requirements
- R1: After reset, `refresh0` and `refresh1` are 0, `done` and `err` are low and `req_ready` is high.
- R2: With `cal_en` high at a clock edge and `cal_chan` 0 or 1, that channel's refresh output equals `cal_count` after the edge. The block also stores (`cal_count`*1000 mod 2^32) and `cal_freq_hz` for later requests. A `cal_chan` of 2 or 3 changes no output and no stored value.
- R3: A valid request writes floor(stored_scaled / floor(stored_freq / `req_khz`)) to the selected channel's output only. The other channel's output keeps its value.
- R4: A request is taken on an edge where `req_valid` and `req_ready` are both high, and its payload is sampled on that edge. `req_ready` is low from the cycle after acceptance through the cycle in which `done` is high.
- R5: A `req_chan` of 2 or 3 gives `done` and `err` in the cycle right after acceptance, and both outputs stay unchanged.
- R6: If `req_khz` is 0, `done` and `err` come in the cycle right after acceptance. If the ratio computes to 0, `done` and `err` come after the edge W+2 cycles from acceptance (34 for W=32). Neither case updates an output.
- R7: `done` lasts one cycle, and `err` is never high without `done`. A successful request's write and `done` take effect on the edge 2W+4 cycles after the accepting edge (68 for W=32).
- R8: The operands of a taken request are fixed at acceptance, so a calibration while it runs does not alter its result. If a calibration of the same channel lands on the edge of the result write, the calibration value wins. A calibration of the other channel on that edge also takes effect. `done` rises either way, without `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_en | input | 1 | Calibration strobe |
| cal_chan | input | 2 | Channel being calibrated |
| cal_count | input | 32 | Refresh count in use on that channel |
| cal_freq_hz | input | 32 | Channel clock frequency in Hz |
| req_valid | input | 1 | Rescale request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_chan | input | 2 | Channel to rescale |
| req_khz | input | 32 | Target clock frequency in kHz |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (with done) |
| refresh0 | output | 32 | Refresh register value for channel 0 |
| refresh1 | output | 32 | Refresh register value for channel 1 |

## Verification
Calibration and the write-back of a computed count can hit the same channel register on the same edge. This collision is provoked by timing `cal_en` to the cycle 68 edges after acceptance, for the same channel and for the other channel. It is judged by reading both refresh outputs when `done` rises: the calibration value must win on its own channel, and the computed value must land on the other. A calibration issued in the middle of a computation is also checked. It must show on the output at once, yet it must not alter the in-flight result.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int RR_NCH = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN1 = 2'd1,
    ST_RUN2 = 2'd2,
    ST_HOLD = 2'd3
  } rr_state_e;
endpackage

// File: rtl/rr_divider.sv
module rr_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    trial;

  assign trial    = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};
  assign quotient = quo_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        quo_q  <= dividend;
        dvs_q  <= divisor;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (!trial[W]) begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= {rem_q[W-2:0], quo_q[W-1]};
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dvs_q != '0) |-> (rem_q < dvs_q)); // R3
endmodule

// File: rtl/rr_chan_slot.sv
module rr_chan_slot #(
  parameter int W     = 32,
  parameter int SCALE = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cal_hit,
  input  logic [W-1:0] cal_count,
  input  logic [W-1:0] cal_freq,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] scaled_ref,
  output logic [W-1:0] ref_freq,
  output logic [W-1:0] refresh
);
  localparam logic [W-1:0] SCALE_W = W'(SCALE);

  logic [W-1:0] scaled_in;
  assign scaled_in = cal_count * SCALE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scaled_ref <= '0;
      ref_freq   <= '0;
      refresh    <= '0;
    end else if (cal_hit) begin
      scaled_ref <= scaled_in;
      ref_freq   <= cal_freq;
      refresh    <= cal_count;
    end else if (wr_hit) begin
      refresh    <= wr_val;
    end
  end

  AST_CAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cal_hit |=> (refresh == $past(cal_count))); // R8
endmodule

// File: rtl/rr_seq.sv
module rr_seq
  import rr_pkg::*;
#(
  parameter int W   = 32,
  parameter int CHW = 2,
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CHW-1:0]   req_chan,
  input  logic [W-1:0]     req_khz,
  input  logic [NCH*W-1:0] st_ref,
  input  logic [NCH*W-1:0] st_freq,
  output logic             div_start,
  output logic [W-1:0]     div_dividend,
  output logic [W-1:0]     div_divisor,
  input  logic             div_done,
  input  logic [W-1:0]     div_quo,
  output logic             wr_en,
  output logic [CHW-1:0]   wr_chan,
  output logic [W-1:0]     wr_val,
  output logic             done,
  output logic             err
);
  rr_state_e    state_q;
  logic [CHW-1:0] chan_q;
  logic [W-1:0] khz_q, ref_q, freq_q, ratio_q;
  logic         start_q, done_q, err_q;
  logic [W-1:0] sel_ref, sel_freq;
  logic         bad_chan;

  assign bad_chan = (req_chan >= CHW'(NCH));

  always_comb begin
    sel_ref  = '0;
    sel_freq = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req_chan == CHW'(i)) begin
        sel_ref  = st_ref[i*W +: W];
        sel_freq = st_freq[i*W +: W];
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign div_start    = start_q;
  assign div_dividend = (state_q == ST_RUN2) ? ref_q : freq_q;
  assign div_divisor  = (state_q == ST_RUN2) ? ratio_q : khz_q;
  assign wr_en        = (state_q == ST_RUN2) && div_done;
  assign wr_chan      = chan_q;
  assign wr_val       = div_quo;
  assign done         = done_q;
  assign err          = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      khz_q   <= '0;
      ref_q   <= '0;
      freq_q  <= '0;
      ratio_q <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          if (bad_chan || req_khz == '0) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_HOLD;
          end else begin
            chan_q  <= req_chan;
            khz_q   <= req_khz;
            ref_q   <= sel_ref;
            freq_q  <= sel_freq;
            start_q <= 1'b1;
            state_q <= ST_RUN1;
          end
        end
        ST_RUN1: if (div_done) begin
          if (div_quo == '0) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_HOLD;
          end else begin
            ratio_q <= div_quo;
            start_q <= 1'b1;
            state_q <= ST_RUN2;
          end
        end
        ST_RUN2: if (div_done) begin
          done_q  <= 1'b1;
          state_q <= ST_HOLD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R7
  AST_NO_ZERO_RATIO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ratio_q != '0)); // R6
endmodule

// File: rtl/refresh_rescaler.sv
module refresh_rescaler
  import rr_pkg::*;
#(
  parameter int W     = 32,
  parameter int CHW   = 2,
  parameter int SCALE = 1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cal_en,
  input  logic [CHW-1:0] cal_chan,
  input  logic [W-1:0]   cal_count,
  input  logic [W-1:0]   cal_freq_hz,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [CHW-1:0] req_chan,
  input  logic [W-1:0]   req_khz,
  output logic           done,
  output logic           err,
  output logic [W-1:0]   refresh0,
  output logic [W-1:0]   refresh1
);
  localparam int NCH = RR_NCH;

  logic [NCH*W-1:0] st_ref, st_freq;
  logic [W-1:0]     refresh_arr [NCH];
  logic             div_start, div_done, wr_en;
  logic [W-1:0]     div_dividend, div_divisor, div_quo, wr_val;
  logic [CHW-1:0]   wr_chan;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    rr_chan_slot #(.W(W), .SCALE(SCALE)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cal_hit    (cal_en && cal_chan == CHW'(g)),
      .cal_count  (cal_count),
      .cal_freq   (cal_freq_hz),
      .wr_hit     (wr_en && wr_chan == CHW'(g)),
      .wr_val     (wr_val),
      .scaled_ref (st_ref[g*W +: W]),
      .ref_freq   (st_freq[g*W +: W]),
      .refresh    (refresh_arr[g])
    );
  end

  assign refresh0 = refresh_arr[0];
  assign refresh1 = refresh_arr[1];

  rr_seq #(.W(W), .CHW(CHW), .NCH(NCH)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_chan     (req_chan),
    .req_khz      (req_khz),
    .st_ref       (st_ref),
    .st_freq      (st_freq),
    .div_start    (div_start),
    .div_dividend (div_dividend),
    .div_divisor  (div_divisor),
    .div_done     (div_done),
    .div_quo      (div_quo),
    .wr_en        (wr_en),
    .wr_chan      (wr_chan),
    .wr_val       (wr_val),
    .done         (done),
    .err          (err)
  );

  rr_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .quotient (div_quo),
    .done     (div_done)
  );

  AST_ERR_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !$past(cal_en)) |-> ($stable(refresh0) && $stable(refresh1))); // R5
endmodule

// File: tb/sim_refresh_rescaler.sv
`timescale 1ns/1ps
module sim_refresh_rescaler;
  localparam int OK_LAT = 68;
  localparam int ZR_LAT = 34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_en = 1'b0;
  logic [1:0]  cal_chan = '0;
  logic [31:0] cal_count = '0, cal_freq_hz = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_chan = '0;
  logic [31:0] req_khz = '0;
  logic        done, err;
  logic [31:0] refresh0, refresh1;

  int n_tests = 0, n_fail = 0, cyc = 0;

  typedef struct {
    string       tag;
    bit          e;
    logic [31:0] r0, r1;
    int          lat, acc;
  } item_t;
  item_t sb[$];

  logic [31:0] m_ref [2];
  logic [31:0] m_freq [2];
  logic [31:0] m_reg [2];

  refresh_rescaler u0 (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] rf, logic [31:0] fq,
                                        logic [31:0] khz, output bit e);
    logic [31:0] ratio;
    e = 1'b0;
    if (khz == 0) begin e = 1'b1; return 0; end
    ratio = fq / khz;
    if (ratio == 0) begin e = 1'b1; return 0; end
    return rf / ratio;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic calib(int ch, logic [31:0] cnt, logic [31:0] fq);
    @(negedge clk);
    cal_en = 1'b1; cal_chan = 2'(ch); cal_count = cnt; cal_freq_hz = fq;
    @(negedge clk);
    cal_en = 1'b0;
    if (ch < 2) begin
      m_ref[ch] = cnt * 32'd1000; m_freq[ch] = fq; m_reg[ch] = cnt;
    end
    chk(refresh0 == m_reg[0], "R2 refresh0 after calibration", refresh0, m_reg[0]);
    chk(refresh1 == m_reg[1], "R2 refresh1 after calibration", refresh1, m_reg[1]);
  endtask

  // driver: pushes expected item, optional calibration at cal_off edges after accept
  task automatic do_req(string tag, int ch, logic [31:0] khz,
                        int cal_off, int cch, logic [31:0] ccnt, logic [31:0] cfq);
    item_t it;
    logic [31:0] val;
    bit e;
    logic [31:0] nreg [2];
    nreg = m_reg;
    it.tag = tag;
    if (ch >= 2) begin e = 1'b1; val = 0; it.lat = 0; end
    else begin
      val = model(m_ref[ch], m_freq[ch], khz, e);
      it.lat = (khz == 0) ? 0 : (e ? ZR_LAT : OK_LAT);
    end
    if (!e) nreg[ch] = val;
    if (cal_off >= 0 && cch < 2 && (cch != ch || cal_off == OK_LAT)) nreg[cch] = ccnt;
    it.e = e; it.r0 = nreg[0]; it.r1 = nreg[1];
    @(negedge clk);
    req_valid = 1'b1; req_chan = 2'(ch); req_khz = khz;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 it.acc = cyc;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R4 ready low after accept", 32'(req_ready), 0);
    if (cal_off >= 1) begin
      repeat (cal_off - 1) @(negedge clk);
      cal_en = 1'b1; cal_chan = 2'(cch); cal_count = ccnt; cal_freq_hz = cfq;
      @(negedge clk);
      cal_en = 1'b0;
      if (cch < 2) begin
        m_ref[cch] = ccnt * 32'd1000; m_freq[cch] = cfq;
        if (cal_off < OK_LAT)
          chk((cch == 0 ? refresh0 : refresh1) == ccnt, "R2 mid-flight calibration visible",
              (cch == 0 ? refresh0 : refresh1), ccnt);
      end
    end
    wait_idle();
    m_reg = nreg;
  endtask

  // monitor: scoreboard compare on done
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) chk(1'b0, "R7 unexpected done", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(err == it.e, {"R5/R6 err ", it.tag}, 32'(err), 32'(it.e));
        chk(refresh0 == it.r0, {"R3/R8 refresh0 ", it.tag}, refresh0, it.r0);
        chk(refresh1 == it.r1, {"R3/R8 refresh1 ", it.tag}, refresh1, it.r1);
        chk(cyc - it.acc == it.lat, {"R7 latency ", it.tag}, 32'(cyc - it.acc), 32'(it.lat));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_ref[i] = 0; m_freq[i] = 0; m_reg[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(refresh0 == 0, "R1 refresh0 reset", refresh0, 0);
    chk(refresh1 == 0, "R1 refresh1 reset", refresh1, 0);
    chk(!done && !err, "R1 done/err low", {30'b0, done, err}, 0);
    chk(req_ready == 1'b1, "R1 ready high", 32'(req_ready), 1);

    // R2 calibration, invalid calibration channel ignored
    calib(1, 32'd1560, 32'd200_000_000);
    calib(0, 32'd1300, 32'd166_000_000);
    calib(2, 32'd9999, 32'd1);

    // R3 main function, several targets
    do_req("ch1 100MHz", 1, 32'd100_000, -1, 0, 0, 0);
    chk(refresh1 == 32'h30C, "R3 ch1 at 100 MHz", refresh1, 32'h30C);
    do_req("ch1 200MHz", 1, 32'd200_000, -1, 0, 0, 0);
    do_req("ch1 83MHz", 1, 32'd83_000, -1, 0, 0, 0);
    chk(refresh1 == 32'h287, "R3 ch1 at 83 MHz", refresh1, 32'h287);
    do_req("ch1 133MHz", 1, 32'd133_000, -1, 0, 0, 0);
    do_req("ch0 83MHz", 0, 32'd83_000, -1, 0, 0, 0);
    do_req("ch0 166MHz", 0, 32'd166_000, -1, 0, 0, 0);

    // R5 invalid channel, R6 zero target and zero ratio
    do_req("bad chan 2", 2, 32'd100_000, -1, 0, 0, 0);
    do_req("bad chan 3", 3, 32'd100_000, -1, 0, 0, 0);
    do_req("zero khz", 0, 32'd0, -1, 0, 0, 0);
    do_req("zero ratio", 1, 32'd300_000_000, -1, 0, 0, 0);

    // R8 mid-flight calibration, same-edge collisions
    do_req("midflight ch0", 0, 32'd83_000, 10, 0, 32'd1000, 32'd100_000_000);
    do_req("collide same", 1, 32'd100_000, OK_LAT, 1, 32'd777, 32'd200_000_000);
    do_req("collide other", 1, 32'd100_000, OK_LAT, 0, 32'd555, 32'd100_000_000);
    do_req("after recal ch0", 0, 32'd50_000, -1, 0, 0, 0);

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7 all requests completed", sb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule